// File: doc/BRIEF.md
# Spectrum Frame Packetizer

The block takes a stream of 64-bit spectral bins and sends them out as raw layer-2 Ethernet frames on a byte-wide GMII-style transmit interface (`txd`, `tx_en`). The bin stream marks the final bin of an event with `bin_last`. The packetizer cuts each event into frames of at most 160 bins. All frames of an event are full except the final one, which carries whatever remains. A 5001-bin event therefore becomes 31 frames of 160 bins and one frame of 41.

Each frame is laid out as follows:
- preamble and SFD;
- fixed destination MAC, source MAC and EtherType;
- an 8-byte application header: event id, packet id, timestamp;
- the bins;
- an 8-byte trailer: constant signature, mode byte, bin count;
- a CRC-32 frame check sequence computed on the fly.

Bins wait in an internal buffer sized for one full frame. A frame is started only once every bin it will carry is present, so the payload never stalls once a frame is under way. A free-running counter with 10 µs resolution at a 125 MHz clock provides the timestamp. The event counter advances after the final frame of each event.

Top module: `spectrum_packetizer`

## Requirements
- R1: Each frame begins with seven 0x55 bytes and one 0xD5 byte. These are followed by, in this order: the 6-byte destination MAC, the 6-byte source MAC, the 2-byte EtherType, the 8-byte application header, the payload, the 8-byte trailer and the 4-byte FCS. All multi-byte fields before the FCS go out most-significant byte first.
- R2: The header contains three fields in this order: a 16-bit event id, a 16-bit packet id and a 32-bit timestamp. The packet id is 0 for the first frame of an event and rises by one for each further frame of that event.
- R3: Each bin occupies 8 payload bytes, sent most-significant byte first, in arrival order. A frame carries at most MAX_BINS (160) bins. A frame ends after the 160th bin or after the bin flagged `bin_last`, whichever comes first. A 5001-bin event gives 31 frames of 160 bins and one frame of 41.
- R4: The trailer carries three fields in this order: the bytes 0x43 0x41 0x50 0x50 0x00, then the `mode` byte sampled when the frame starts, then a 16-bit count of the bins in that frame.
- R5: The FCS is the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, result inverted). It covers the first destination MAC byte through the last trailer byte and is sent least-significant byte first.
- R6: `tx_en` stays low for at least 12 cycles between frames, and `txd` is 0 whenever `tx_en` is low.
- R7: A frame starts only when 160 bins, or all remaining bins of the event up to the one flagged last, are buffered. The buffer never holds more than 160 bins, and `bin_ready` is low while it is full.
- R8: The event id is 0 after reset. It rises by one, wrapping at 16 bits, after the final frame of each event, and the packet id returns to 0 at the same time.
- R9: The timestamp is 0 at reset and advances by one every TS_DIV (1250) clock cycles. It is captured at the cycle the frame begins.
- R10: During and right after reset, `tx_en` is 0, `txd` is 0 and `bin_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bin_data | input | 64 | Spectral bin value |
| bin_valid | input | 1 | Bin on `bin_data` is offered |
| bin_last | input | 1 | Offered bin is the final one of its event |
| bin_ready | output | 1 | Buffer can accept a bin this cycle |
| mode | input | 8 | Mode byte copied into each frame trailer |
| txd | output | 8 | Transmit byte |
| tx_en | output | 1 | Transmit byte is valid |

## Verification
The bench goes after several event lengths, each of which breaks a specific kind of bug:
- A single bin: a packetizer that waited for a full frame would hang.
- Exactly 160 bins: an off-by-one end test would send an empty second frame.
- 161 bins: a one-bin final frame is produced, which catches splitting errors.
- A full 5001-bin event: this checks the 41-bin tail and back-pressure from a full buffer.

One event is held at 159 buffered bins for hundreds of cycles. An early start would show up as a frame that stalls or carries too few bins. Every frame's FCS, count, packet id and event id are recomputed in the bench, so a wrong CRC byte order, a packet id that does not reset, or a stale mode byte each turn into a mismatch.

// File: rtl/pkz_pkg.sv
// Shared types and the CRC-32 byte step for the spectrum packetizer.
package pkz_pkg;

    // Which section of a frame the next output byte belongs to.
    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_HDR, S_PAY, S_TRL, S_FCS, S_GAP
    } pkz_state_t;

    // One byte of the reflected CRC-32, LSB of the byte first.
    function automatic logic [31:0] crc32_byte(logic [31:0] c, logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r >> 1) ^ (((r[0] ^ d[i]) != 1'b0) ? 32'hEDB88320 : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/pkz_fifo.sv
// Bin buffer: holds up to DEPTH bins with their last flags.
// Read data is shown ahead (valid while count != 0). Assumes the
// writer never pushes when full and the reader never pops when empty.
module pkz_fifo #(
    parameter int DW    = 64,
    parameter int DEPTH = 160,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          din_last,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          dout_last,
    output logic [CW-1:0] count,
    output logic          has_last
);
    logic [DW:0]   mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] lasts;

    assign dout      = mem[rd_ptr][DW-1:0];
    assign dout_last = mem[rd_ptr][DW];
    assign has_last  = (lasts != '0);

    // Storage write, no reset needed on the array.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= {din_last, din};
    end

    // Pointers, occupancy and count of stored last flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            lasts  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            case ({push && din_last, pop && dout_last})
                2'b10:   lasts <= lasts + 1'b1;
                2'b01:   lasts <= lasts - 1'b1;
                default: lasts <= lasts;
            endcase
        end
    end
endmodule

// File: rtl/pkz_crc.sv
// CRC-32 accumulator: cleared to all ones, folds one byte per enabled cycle.
module pkz_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    import pkz_pkg::*;

    // Running remainder update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= 32'hFFFF_FFFF;
        else if (en)         crc <= crc32_byte(crc, din);
    end
endmodule

// File: rtl/pkz_tick.sv
// Timestamp counter: advances once every DIV clock cycles from reset.
module pkz_tick #(
    parameter int DIV = 1250,
    parameter int TW  = 32,
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] ts
);
    logic [PW-1:0] pre;

    // Prescaler and timestamp advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
            ts  <= '0;
        end else if (pre == PW'(DIV - 1)) begin
            pre <= '0;
            ts  <= ts + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/spectrum_packetizer.sv
// Spectrum packetizer top. Buffers bins, splits each event (ended by
// bin_last) into frames of up to MAX_BINS bins and emits raw Ethernet
// frames byte by byte with header, trailer and CRC-32 FCS.
// Assumes the byte clock runs continuously and MAX_BINS <= 65535.
module spectrum_packetizer #(
    parameter int          MAX_BINS = 160,
    parameter int          TS_DIV   = 1250,
    parameter int          GAP_LEN  = 12,
    parameter logic [47:0] DST_MAC  = 48'h02_00_00_00_00_01,
    parameter logic [47:0] SRC_MAC  = 48'h02_00_00_00_00_02,
    parameter logic [15:0] ETH_TYPE = 16'h88B5,
    localparam int BIN_W     = 64,
    localparam int BIN_BYTES = BIN_W / 8,
    localparam int PRE_BYTES = 8,
    localparam int HDR_BYTES = 22,
    localparam int TRL_BYTES = 8,
    localparam int FCS_BYTES = 4,
    localparam int CW        = $clog2(MAX_BINS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BIN_W-1:0] bin_data,
    input  logic             bin_valid,
    input  logic             bin_last,
    output logic             bin_ready,
    input  logic [7:0]       mode,
    output logic [7:0]       txd,
    output logic             tx_en
);
    import pkz_pkg::*;

    pkz_state_t       state;
    logic [7:0]       idx;
    logic [CW-1:0]    bin_cnt;
    logic             ev_end;
    logic [15:0]      evid, pktid;
    logic [31:0]      ts, ts_cap;
    logic [7:0]       mode_cap;
    logic [BIN_W-1:0] fifo_dout;
    logic             fifo_last, fifo_has_last, pop, push;
    logic [CW-1:0]    fifo_cnt;
    logic [31:0]      crc;
    logic [7:0]       nb;
    logic             nen, crc_en;
    logic [HDR_BYTES*8-1:0] hdr_vec;
    logic [TRL_BYTES*8-1:0] trl_vec;

    assign bin_ready = (fifo_cnt < CW'(MAX_BINS));
    assign push      = bin_valid && bin_ready;
    assign pop       = (state == S_PAY) && (idx == 8'(BIN_BYTES - 1));
    assign hdr_vec   = {DST_MAC, SRC_MAC, ETH_TYPE, evid, pktid, ts_cap};
    assign trl_vec   = {40'h43_41_50_50_00, mode_cap, 16'(bin_cnt)};
    assign crc_en    = (state == S_HDR) || (state == S_PAY) || (state == S_TRL);

    pkz_fifo #(.DW(BIN_W), .DEPTH(MAX_BINS)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(bin_data), .din_last(bin_last),
        .pop(pop), .dout(fifo_dout), .dout_last(fifo_last), .count(fifo_cnt),
        .has_last(fifo_has_last)
    );

    pkz_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clear(state == S_PRE), .en(crc_en),
        .din(nb), .crc(crc)
    );

    pkz_tick #(.DIV(TS_DIV), .TW(32)) u_tick (.clk(clk), .rst_n(rst_n), .ts(ts));

    // Select the byte to be driven at the next edge.
    always_comb begin
        nb  = 8'h00;
        nen = 1'b1;
        case (state)
            S_PRE:   nb = (idx == 8'(PRE_BYTES - 1)) ? 8'hD5 : 8'h55;
            S_HDR:   nb = hdr_vec[8*(HDR_BYTES - 1 - int'(idx)) +: 8];
            S_PAY:   nb = fifo_dout[8*(BIN_BYTES - 1 - int'(idx)) +: 8];
            S_TRL:   nb = trl_vec[8*(TRL_BYTES - 1 - int'(idx)) +: 8];
            S_FCS:   nb = ~crc[8*int'(idx) +: 8];
            default: nen = 1'b0;
        endcase
    end

    // Registered GMII-style outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd   <= 8'h00;
            tx_en <= 1'b0;
        end else begin
            txd   <= nb;
            tx_en <= nen;
        end
    end

    // Frame sequencer with event and packet numbering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            idx      <= '0;
            bin_cnt  <= '0;
            ev_end   <= 1'b0;
            evid     <= '0;
            pktid    <= '0;
            ts_cap   <= '0;
            mode_cap <= '0;
        end else begin
            idx <= idx + 1'b1;
            case (state)
                S_IDLE: begin
                    idx <= '0;
                    if (fifo_cnt >= CW'(MAX_BINS) || fifo_has_last) begin
                        state    <= S_PRE;
                        ts_cap   <= ts;
                        mode_cap <= mode;
                        bin_cnt  <= '0;
                        ev_end   <= 1'b0;
                    end
                end
                S_PRE: if (idx == 8'(PRE_BYTES - 1)) begin
                    state <= S_HDR;
                    idx   <= '0;
                end
                S_HDR: if (idx == 8'(HDR_BYTES - 1)) begin
                    state <= S_PAY;
                    idx   <= '0;
                end
                S_PAY: if (pop) begin
                    idx     <= '0;
                    bin_cnt <= bin_cnt + 1'b1;
                    if (fifo_last || (bin_cnt == CW'(MAX_BINS - 1))) begin
                        state  <= S_TRL;
                        ev_end <= fifo_last;
                    end
                end
                S_TRL: if (idx == 8'(TRL_BYTES - 1)) begin
                    state <= S_FCS;
                    idx   <= '0;
                end
                S_FCS: if (idx == 8'(FCS_BYTES - 1)) begin
                    state <= S_GAP;
                    idx   <= '0;
                    if (ev_end) begin
                        evid  <= evid + 1'b1;
                        pktid <= '0;
                    end else begin
                        pktid <= pktid + 1'b1;
                    end
                end
                S_GAP: if (idx == 8'(GAP_LEN - 1)) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pkz_chk.sv
// Assertion checker for spectrum_packetizer, attached by bind below.
module pkz_chk #(
    parameter int MAX_BINS = 160,
    parameter int GAP_LEN  = 12,
    localparam int CW      = $clog2(MAX_BINS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_en,
    input logic [7:0]    txd,
    input logic [CW-1:0] fifo_cnt,
    input logic [CW-1:0] bin_cnt,
    input logic          in_pay,
    input logic [15:0]   evid,
    input logic [15:0]   pktid,
    input logic [31:0]   ts
);
    logic [7:0] low_cnt;

    // Count idle cycles since the last transmitted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)         low_cnt <= 8'hFF;
        else if (tx_en)     low_cnt <= 8'h00;
        else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 1'b1;
    end

    p_ifg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (low_cnt >= 8'(GAP_LEN)));
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (txd == 8'h00));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(MAX_BINS));
    p_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_pay |-> (fifo_cnt != '0));
    p_bin_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bin_cnt <= CW'(MAX_BINS));
    p_evid_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (evid != $past(evid)) |-> ((evid == $past(evid) + 16'd1) && (pktid == 16'd0)));
    p_ts_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ts != $past(ts)) |-> (ts == $past(ts) + 32'd1));
endmodule

bind spectrum_packetizer pkz_chk #(.MAX_BINS(MAX_BINS), .GAP_LEN(GAP_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd), .fifo_cnt(fifo_cnt),
    .bin_cnt(bin_cnt), .in_pay(state == pkz_pkg::S_PAY), .evid(evid),
    .pktid(pktid), .ts(ts)
);

// File: tb/spectrum_packetizer_tb.sv
// Self-checking bench: random-gap and directed events, frames parsed and
// compared against values computed here.
module spectrum_packetizer_tb;
    localparam int          NB   = 160;
    localparam int          TSD  = 1250;
    localparam logic [47:0] DMAC = 48'h0A_1B_2C_3D_4E_5F;
    localparam logic [47:0] SMAC = 48'h06_11_22_33_44_55;
    localparam logic [15:0] ETY  = 16'h88B6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] bin_data = '0;
    logic        bin_valid = 1'b0, bin_last = 1'b0, bin_ready;
    logic [7:0]  mode = 8'h00;
    logic [7:0]  txd;
    logic        tx_en;

    spectrum_packetizer #(.MAX_BINS(NB), .TS_DIV(TSD), .GAP_LEN(12),
        .DST_MAC(DMAC), .SRC_MAC(SMAC), .ETH_TYPE(ETY)) u_dut (
        .clk(clk), .rst_n(rst_n), .bin_data(bin_data), .bin_valid(bin_valid),
        .bin_last(bin_last), .bin_ready(bin_ready), .mode(mode), .txd(txd), .tx_en(tx_en)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    logic [63:0] expq[$];
    int evlen[$];
    int evmode[$];
    int ev_done = 0, cur_ev = 0, cur_pkt = 0, rem = 0;
    int frames_started = 0, quiet_bad = 0, rdy_low = 0, low_n = 0;
    int cyc = 0, fcyc = 0, flen = 0;
    logic prev_en = 1'b0;
    logic [7:0] fb [0:1399];

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref(int first, int last_i);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = first; i <= last_i; i++) begin
            c = c ^ {24'h0, fb[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [63:0] field(int off, int nbytes);
        logic [63:0] v = '0;
        for (int i = 0; i < nbytes; i++) v = {v[55:0], fb[off + i]};
        return v;
    endfunction

    task automatic check_frame();
        int n, o, bad, tse, tsa;
        logic [31:0] crc;
        if (cur_ev >= evlen.size()) begin
            chk("R3 unexpected frame", 1, 0);
            return;
        end
        if (rem == 0) rem = evlen[cur_ev];
        n = (rem > NB) ? NB : rem;
        bad = 0;
        for (int i = 0; i < 7; i++) if (fb[i] != 8'h55) bad++;
        chk("R1 preamble", {bad[31:0], fb[7]}, {32'd0, 8'hD5});
        chk("R1 dst mac", field(8, 6), {16'h0, DMAC});
        chk("R1 src mac", field(14, 6), {16'h0, SMAC});
        chk("R1 ethertype", field(20, 2), {48'h0, ETY});
        chk("R8 event id", field(22, 2), 64'(cur_ev & 16'hFFFF));
        chk("R2 packet id", field(24, 2), 64'(cur_pkt));
        tsa = int'(field(26, 4));
        tse = (fcyc - 2) / TSD;
        chk("R9 timestamp", 64'(tsa), ((tsa - tse) <= 1 && (tse - tsa) <= 1) ? 64'(tsa) : 64'(tse));
        chk("R3 frame length", 64'(flen), 64'(8 + 22 + 8 * n + 8 + 4));
        if (flen == 8 + 22 + 8 * n + 8 + 4) begin
            bad = 0;
            for (int b = 0; b < n; b++) begin
                logic [63:0] e;
                e = (expq.size() > 0) ? expq.pop_front() : 64'h0;
                if (field(30 + 8 * b, 8) !== e) bad++;
            end
            chk("R3 payload bins", 64'(bad), 0);
            o = 30 + 8 * n;
            chk("R4 signature", field(o, 5), 64'h43_41_50_50_00);
            chk("R4 mode", {56'h0, fb[o + 5]}, 64'(evmode[cur_ev]));
            chk("R4 count", field(o + 6, 2), 64'(n));
            crc = crc_ref(8, o + 7);
            chk("R5 fcs", {32'h0, fb[o + 11], fb[o + 10], fb[o + 9], fb[o + 8]}, {32'h0, crc});
        end
        rem -= n;
        cur_pkt++;
        if (rem == 0) begin
            ev_done++;
            cur_ev++;
            cur_pkt = 0;
        end
    endtask

    // Cycle counter since reset release.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Output monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bin_valid && !bin_ready) rdy_low++;
            if (tx_en) begin
                if (!prev_en) begin
                    if (frames_started > 0) chk("R6 gap", 64'(low_n >= 12), 1);
                    frames_started++;
                    fcyc = cyc;
                    flen = 0;
                end
                if (flen < 1400) fb[flen] = txd;
                flen++;
                low_n = 0;
            end else begin
                if (txd != 8'h00) quiet_bad++;
                low_n++;
                if (prev_en) check_frame();
            end
            prev_en = tx_en;
        end
    end

    task automatic push(logic [63:0] d, logic l);
        logic ok;
        bin_data  = d;
        bin_last  = l;
        bin_valid = 1'b1;
        forever begin
            ok = bin_ready;
            @(negedge clk);
            if (ok) break;
        end
        bin_valid = 1'b0;
        bin_last  = 1'b0;
    endtask

    task automatic send_event(int n, int mv, int gapmax, int pause_at);
        int idx;
        idx = evlen.size();
        evlen.push_back(n);
        evmode.push_back(mv);
        mode = 8'(mv);
        for (int i = 0; i < n; i++) begin
            logic [63:0] d;
            if (i == pause_at) begin
                int fs;
                fs = frames_started;
                repeat (400) @(negedge clk);
                chk("R7 no early start", 64'(frames_started), 64'(fs));
            end
            d = {$urandom, $urandom};
            expq.push_back(d);
            push(d, i == n - 1);
            if (gapmax > 0) repeat ($urandom % (gapmax + 1)) @(negedge clk);
        end
        while (ev_done < idx + 1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        chk("R10 reset tx_en", 64'(tx_en), 0);
        chk("R10 reset txd", 64'(txd), 0);
        chk("R10 reset ready", 64'(bin_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", 64'(bin_ready), 1);
        send_event(200, 8'h3C, 0, 159);   // R7 hold at 159 bins, then 160+40
        send_event(1, 8'hA5, 0, -1);      // single-bin event
        send_event(160, 8'h01, 2, -1);    // exact frame boundary
        send_event(161, 8'h7E, 1, -1);    // one-bin tail
        send_event(300 + int'($urandom % 400), 8'h5A, 3, -1);
        send_event(5001, 8'hC3, 0, -1);   // full event: 31x160 + 41
        chk("R3 full event frame count", 64'(cur_pkt), 0);
        send_event(50 + int'($urandom % 200), 8'h0F, 2, -1);
        repeat (50) @(negedge clk);
        chk("R7 ready dropped while full", 64'(rdy_low > 0), 1);
        chk("R6 txd quiet", 64'(quiet_bad), 0);
        chk("R8 events completed", 64'(ev_done), 7);
        chk("R3 all bins consumed", 64'(expq.size()), 0);
        chk("R3 total frames", 64'(frames_started), 64'(2 + 1 + 1 + 2 + 0 + 32 + 0) + 64'((evlen[4] + NB - 1) / NB) + 64'((evlen[6] + NB - 1) / NB));
        finish_run();
    end
endmodule